// File: doc/BRIEF.md
# High-Byte-Masked Indexed Store Generator

This block produces the address and data for a small family of indexed store operations whose stored value is gated by the high byte of the operand address plus one. The execute stage gives it an opcode, the A, X and Y register values and the 16-bit operand address. The operand address is the unindexed address: the absolute operand, or the pointer already fetched for the indirect form. One clock edge later the block drives a store address, a store byte and a one-cycle write strobe. For the stack-transfer variant it also drives a stack-pointer load with the new value.

Four operations are decoded. The first stores Y, indexed by X. The second stores X, indexed by Y. The third stores A AND X, indexed by Y, in an absolute form and an indirect form. The fourth first copies A AND X into the stack pointer and then stores that value, indexed by Y. In all four the stored byte is further ANDed with the operand's high byte plus one. A, X, Y and the status flags are never written by this block. An elaboration parameter selects an optional mode that models a misdirected store: when adding the index carries out of the low address byte, the high address byte is replaced by the stored byte.

Top module: `mask_store_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, writeStrobe and spLoad are low and storeAddr, storeData and spValue are zero.
- R2: A request with a decoded opcode sampled at a rising edge raises writeStrobe for exactly that following cycle; without a new request it is low in the next cycle, and back-to-back requests keep it high on consecutive cycles.
- R3: A request with any opcode other than 0x9B, 0x9C, 0x9E, 0x9F or 0x93 raises neither writeStrobe nor spLoad.
- R4: Opcode 0x9C stores regY AND (baseAddr[15:8]+1) at baseAddr+regX.
- R5: Opcode 0x9E stores regX AND (baseAddr[15:8]+1) at baseAddr+regY.
- R6: Opcodes 0x9F and 0x93 store regA AND regX AND (baseAddr[15:8]+1) at baseAddr+regY.
- R7: Opcode 0x9B raises spLoad with spValue = regA AND regX, and stores that value AND (baseAddr[15:8]+1) at baseAddr+regY.
- R8: The mask uses the high byte of baseAddr before the index is added, even when the index carries into the high byte.
- R9: The mask byte wraps modulo 256, so a high byte of 0xFF gives a mask of 0x00 and a stored byte of 0x00.
- R10: With CROSS_MODE = 0 the store address is the full 16-bit sum of baseAddr and the index, wrapping past 0xFFFF.
- R11: With CROSS_MODE = 1, when baseAddr[7:0] plus the index exceeds 0xFF, storeAddr is {storeData, low byte of the sum}; otherwise it is the same as with CROSS_MODE = 0.
- R12: spLoad is raised only for opcode 0x9B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Store request this cycle |
| opcode | input | 8 | Operation code |
| regA | input | 8 | Accumulator value |
| regX | input | 8 | X register value |
| regY | input | 8 | Y register value |
| baseAddr | input | 16 | Unindexed operand address |
| writeStrobe | output | 1 | One-cycle store enable |
| storeAddr | output | 16 | Store address |
| storeData | output | 8 | Store byte |
| spLoad | output | 1 | Stack-pointer load enable |
| spValue | output | 8 | New stack-pointer value |

## Verification
Every result appears on the cycle after the edge that samples the request, because decode is combinational and the outputs pass through one register stage. The bench drives inputs on the falling edge, waits one rising edge, and reads all outputs on the next falling edge. It then drops the request and reads the outputs again one cycle later to confirm that the strobe lasted a single cycle. A second instance built with the crossing mode on receives the same stimulus, and its address is compared at the same point.

// File: rtl/msu_pkg.sv
package msu_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_Y, SRC_X, SRC_AX} srcSel_e;

  typedef struct packed {
    logic    fire;
    logic    spLoad;
    logic    idxByX;
    srcSel_e src;
  } ctrlStrobe_t;

  localparam logic [7:0] OP_AX_TO_SP = 8'h9B;
  localparam logic [7:0] OP_Y_IDX_X  = 8'h9C;
  localparam logic [7:0] OP_X_IDX_Y  = 8'h9E;
  localparam logic [7:0] OP_AX_ABS_Y = 8'h9F;
  localparam logic [7:0] OP_AX_IND_Y = 8'h93;
endpackage

// File: rtl/msu_control.sv
module msu_control
  import msu_pkg::*;
(
  input  logic        reqValid,
  input  logic [7:0]  opcode,
  output ctrlStrobe_t ctrl
);
  always_comb begin
    ctrl = '{fire: 1'b0, spLoad: 1'b0, idxByX: 1'b0, src: SRC_NONE};
    if (reqValid) begin
      case (opcode)
        OP_Y_IDX_X:  ctrl = '{fire: 1'b1, spLoad: 1'b0, idxByX: 1'b1, src: SRC_Y};
        OP_X_IDX_Y:  ctrl = '{fire: 1'b1, spLoad: 1'b0, idxByX: 1'b0, src: SRC_X};
        OP_AX_ABS_Y,
        OP_AX_IND_Y: ctrl = '{fire: 1'b1, spLoad: 1'b0, idxByX: 1'b0, src: SRC_AX};
        OP_AX_TO_SP: ctrl = '{fire: 1'b1, spLoad: 1'b1, idxByX: 1'b0, src: SRC_AX};
        default:     ctrl = '{fire: 1'b0, spLoad: 1'b0, idxByX: 1'b0, src: SRC_NONE};
      endcase
    end
  end
endmodule

// File: rtl/msu_datapath.sv
module msu_datapath
  import msu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit CROSS_MODE = 1'b0,
  localparam int ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regX,
  input  logic [DATA_W-1:0] regY,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              writeStrobe,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData,
  output logic              spLoad,
  output logic [DATA_W-1:0] spValue
);
  logic [DATA_W-1:0] maskByte, indexVal, srcVal, dataNext;
  logic [DATA_W:0]   lowSum;
  logic [ADDR_W-1:0] fullAddr, addrNext;
  logic              pageCross;

  always_comb begin
    maskByte  = baseAddr[ADDR_W-1:DATA_W] + DATA_W'(1);
    indexVal  = ctrl.idxByX ? regX : regY;
    lowSum    = {1'b0, baseAddr[DATA_W-1:0]} + {1'b0, indexVal};
    pageCross = lowSum[DATA_W];
    fullAddr  = baseAddr + {{DATA_W{1'b0}}, indexVal};
    case (ctrl.src)
      SRC_Y:   srcVal = regY;
      SRC_X:   srcVal = regX;
      SRC_AX:  srcVal = regA & regX;
      default: srcVal = '0;
    endcase
    dataNext = srcVal & maskByte;
    addrNext = (CROSS_MODE && pageCross) ? {dataNext, lowSum[DATA_W-1:0]} : fullAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeStrobe <= 1'b0;
      spLoad      <= 1'b0;
      storeAddr   <= '0;
      storeData   <= '0;
      spValue     <= '0;
    end else begin
      writeStrobe <= ctrl.fire;
      spLoad      <= ctrl.spLoad;
      if (ctrl.fire) begin
        storeAddr <= addrNext;
        storeData <= dataNext;
      end
      if (ctrl.spLoad) spValue <= regA & regX;
    end
  end

  // R8 R9
  mask_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeStrobe |-> ((storeData & ~($past(baseAddr[ADDR_W-1:DATA_W]) + DATA_W'(1))) == '0));

  // R7
  sp_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    spLoad |-> (spValue == ($past(regA) & $past(regX))));

  generate
    if (!CROSS_MODE) begin : g_plainAddr
      // R10
      addr_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
        writeStrobe |-> (storeAddr == $past(baseAddr) + {{DATA_W{1'b0}},
          ($past(ctrl.idxByX) ? $past(regX) : $past(regY))}));
    end
  endgenerate
endmodule

// File: rtl/mask_store_unit.sv
module mask_store_unit
  import msu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit CROSS_MODE = 1'b0,
  localparam int ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regX,
  input  logic [DATA_W-1:0] regY,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              writeStrobe,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData,
  output logic              spLoad,
  output logic [DATA_W-1:0] spValue
);
  ctrlStrobe_t ctrl;

  msu_control u_control (
    .reqValid (reqValid),
    .opcode   (opcode),
    .ctrl     (ctrl)
  );

  msu_datapath #(.DATA_W(DATA_W), .CROSS_MODE(CROSS_MODE)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .regA        (regA),
    .regX        (regX),
    .regY        (regY),
    .baseAddr    (baseAddr),
    .writeStrobe (writeStrobe),
    .storeAddr   (storeAddr),
    .storeData   (storeData),
    .spLoad      (spLoad),
    .spValue     (spValue)
  );

  // R2
  strobe_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeStrobe |-> $past(reqValid));

  // R12
  sp_with_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    spLoad |-> (writeStrobe && $past(opcode) == 8'h9B));
endmodule

// File: tb/mask_store_unit_bench.sv
module mask_store_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  opcode = '0, regA = '0, regX = '0, regY = '0;
  logic [15:0] baseAddr = '0;
  logic        writeStrobe, spLoad, crossStrobe, crossSp;
  logic [15:0] storeAddr, crossAddr;
  logic [7:0]  storeData, spValue, crossData, crossSpVal;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mask_store_unit u_mask_store_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .regA(regA), .regX(regX), .regY(regY), .baseAddr(baseAddr),
    .writeStrobe(writeStrobe), .storeAddr(storeAddr), .storeData(storeData),
    .spLoad(spLoad), .spValue(spValue));

  mask_store_unit #(.CROSS_MODE(1'b1)) u_mask_store_unit_cross (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode),
    .regA(regA), .regX(regX), .regY(regY), .baseAddr(baseAddr),
    .writeStrobe(crossStrobe), .storeAddr(crossAddr), .storeData(crossData),
    .spLoad(crossSp), .spValue(crossSpVal));

  // opcode, A, X, Y, base
  localparam int NVEC = 9;
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h9C, 8'h00, 8'h05, 8'hFF, 16'h1234},
    {8'h9E, 8'h00, 8'hF0, 8'h10, 16'h7700},
    {8'h9F, 8'h3C, 8'hF6, 8'h01, 16'h71FF},
    {8'h93, 8'hFF, 8'hFF, 8'h20, 16'h0040},
    {8'h9B, 8'hE7, 8'h7E, 8'h05, 16'h7700},
    {8'h9C, 8'h00, 8'h90, 8'hAB, 16'hFF80},
    {8'h9E, 8'h00, 8'hFF, 8'h20, 16'h20F0},
    {8'hAD, 8'h11, 8'h22, 8'h33, 16'h4444},
    {8'h9B, 8'hFF, 8'h0F, 8'h02, 16'h40FF}
  };

  function automatic bit isStore(input logic [7:0] op);
    return op == 8'h9B || op == 8'h9C || op == 8'h9E || op == 8'h9F || op == 8'h93;
  endfunction

  function automatic logic [7:0] expData(input logic [7:0] op, a, x, y, input logic [15:0] base);
    logic [7:0] m;
    m = base[15:8] + 8'd1;
    case (op)
      8'h9C: return y & m;
      8'h9E: return x & m;
      8'h9F, 8'h93, 8'h9B: return a & x & m;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] expAddr(input logic [7:0] op, a, x, y,
                                          input logic [15:0] base, input bit crossMode);
    logic [7:0]  idx;
    logic [15:0] sum;
    logic [8:0]  low;
    idx = (op == 8'h9C) ? x : y;
    sum = base + {8'h00, idx};
    low = {1'b0, base[7:0]} + {1'b0, idx};
    if (crossMode && low[8]) return {expData(op, a, x, y, base), low[7:0]};
    return sum;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [47:0] v, input logic valid);
    {opcode, regA, regX, regY, baseAddr} = v;
    reqValid = valid;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: during reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 strobe in reset", 32'(writeStrobe), 0);
    chk("R1 spLoad in reset", 32'(spLoad), 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 strobe after reset", 32'(writeStrobe), 0);
    chk("R1 addr after reset", 32'(storeAddr), 0);
    chk("R1 data after reset", 32'(storeData), 0);
    chk("R1 spValue after reset", 32'(spValue), 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] op, a, x, y;
      logic [15:0] b;
      logic [7:0] spPrev;
      {op, a, x, y, b} = VEC[i];
      spPrev = spValue;
      drive(VEC[i], 1'b1);
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      if (isStore(op)) begin
        chk($sformatf("R2 strobe vec %0d", i), 32'(writeStrobe), 1);
        // R4 R5 R6 R7 R8 R9 data
        chk($sformatf("R4-6/R7/R8/R9 data vec %0d", i), 32'(storeData),
            32'(expData(op, a, x, y, b)));
        // R10 address
        chk($sformatf("R10 addr vec %0d", i), 32'(storeAddr),
            32'(expAddr(op, a, x, y, b, 1'b0)));
        // R11 crossing mode address
        chk($sformatf("R11 cross addr vec %0d", i), 32'(crossAddr),
            32'(expAddr(op, a, x, y, b, 1'b1)));
      end else begin
        chk($sformatf("R3 no strobe vec %0d", i), 32'(writeStrobe), 0);
        chk($sformatf("R3 no spLoad vec %0d", i), 32'(spLoad), 0);
      end
      // R12 spLoad only for 9B
      chk($sformatf("R12 spLoad vec %0d", i), 32'(spLoad), 32'(op == 8'h9B));
      // R7 stack value
      chk($sformatf("R7 spValue vec %0d", i), 32'(spValue),
          32'((op == 8'h9B) ? (a & x) : spPrev));
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2 strobe drops vec %0d", i), 32'(writeStrobe), 0);
      chk($sformatf("R2 spLoad drops vec %0d", i), 32'(spLoad), 0);
    end

    // R2: back-to-back requests
    drive(VEC[0], 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 back-to-back first", 32'(writeStrobe), 1);
    drive(VEC[1], 1'b1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 back-to-back second", 32'(writeStrobe), 1);
    chk("R5 back-to-back data", 32'(storeData), 32'h70);
    @(posedge clk);
    @(negedge clk);
    chk("R2 back-to-back end", 32'(writeStrobe), 0);

    // R11: no carry in crossing mode leaves address as plain sum
    drive({8'h9F, 8'hFF, 8'hFF, 8'h0F, 16'h3010}, 1'b1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 no-carry cross addr", 32'(crossAddr), 32'h301F);
    chk("R6 no-carry data", 32'(crossData), 32'h31);

    // R1: reset clears outputs after activity
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reapplied spValue", 32'(spValue), 0);
    chk("R1 reapplied addr", 32'(storeAddr), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule